// File: doc/BRIEF.md
# Interleaved Chroma DC Reconstruction

This block rebuilds one chroma component of a 4x4 block when the block's residual is a DC value only. The chroma planes sit in memory interleaved byte by byte, so each row handed to the block is eight bytes. Four of those bytes (the even positions) belong to the component being rebuilt and four (the odd positions) belong to the other component.

A start pulse captures a DC value that has already been dequantized. The block rounds it down to a residual by a rounding arithmetic shift of six bits. Four row steps follow. Each step supplies a prediction row and the output row as it currently stands. The block takes the even bytes of the prediction row, adds the residual to each, clips the results to the 8-bit pixel range, and writes them into the even bytes of the current output row. The odd bytes pass through unchanged. The merged row comes back one cycle later. Dequantization, AC coefficients and memory addressing are handled elsewhere.

Top module: `chroma_dc_recon`

## Requirements
- R1: After reset, `busy`, `out_valid` and `done` are 0 and `out_row` is all zeros.
- R2: When `start` is 1 and `busy` is 0, `dc_in` (a signed 16-bit value) is captured, and `busy` is 1 from the next cycle onward. The residual is (dc_in + 32) >>> 6, worked out without overflow. That gives 0 for dc_in = 31, 1 for dc_in = 32, -1 for dc_in = -33, 512 for 32767 and -512 for -32768.
- R3: Bytes are numbered from the low end (byte k is bits [8k+7:8k]). Output byte 2i, for i = 0..3, equals prediction byte 2i plus the residual, with the prediction byte zero-extended and the result clipped to the range 0 to 255.
- R4: Each odd byte (1, 3, 5, 7) of `out_row` equals the same byte of the `cur_row` that was presented with the row.
- R5: A row is accepted in a cycle where `in_valid` and `busy` are both 1. `out_valid` is 1, with the merged row on `out_row`, in exactly the next cycle.
- R6: Rows are numbered in the order they are accepted. `done` is 1 in the same cycle as the `out_valid` of the fourth row, and 0 at all other times. `busy` is 0 from the cycle of `done` onward.
- R7: While `busy` is 0, `in_valid` is ignored: no `out_valid` follows and `out_row` keeps its value.
- R8: While `busy` is 1, `start` is ignored. The captured residual and the row count do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a block and captures `dc_in` |
| dc_in | input | 16 | Dequantized DC value, signed |
| in_valid | input | 1 | A row is presented on `pred_row` and `cur_row` |
| pred_row | input | 64 | Interleaved prediction row |
| cur_row | input | 64 | Current interleaved output row |
| busy | output | 1 | A block is in progress |
| out_valid | output | 1 | `out_row` holds a merged row |
| out_row | output | 64 | Merged interleaved row |
| done | output | 1 | Fourth merged row is on `out_row` |

## Verification
The assertions assume that `start` and `in_valid` are never X after reset. They also assume that rows arrive only while a block is running, except when a test sets out to show that idle rows are ignored. The odd-byte and latency properties compare `out_row` against `cur_row` from the previous cycle. This requires `cur_row` to be held until the edge that accepts the row. The bench changes every input only on the falling clock edge, which meets that condition. It deliberately pulses `start` during a running block and `in_valid` while idle, to reach the ignore cases.

// File: rtl/chroma_dc_pkg.sv
// Shared constants and types for the interleaved chroma DC reconstruction.
// Assumes a 6-bit rounding shift from dequantized DC to residual.
package chroma_dc_pkg;
    localparam int unsigned RES_SHIFT = 6;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_t;
endpackage

// File: rtl/cdc_residual.sv
// Captures the dequantized DC on a load strobe and holds the rounded residual.
// Assumes dc_in is two's complement; the sum is widened by one bit so it cannot overflow.
module cdc_residual #(
    parameter int DC_W  = 16,
    parameter int RES_W = DC_W + 1 - chroma_dc_pkg::RES_SHIFT
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [DC_W-1:0]         dc_in,
    output logic signed [RES_W-1:0] residual
);
    import chroma_dc_pkg::*;

    localparam int SUM_W = DC_W + 1;
    localparam logic signed [SUM_W-1:0] HALF = SUM_W'(1 << (RES_SHIFT - 1));

    logic signed [SUM_W-1:0] sum_w;
    logic signed [SUM_W-1:0] shifted_w;

    // Rounding shift of the widened DC value.
    always_comb begin
        sum_w     = $signed({dc_in[DC_W-1], dc_in}) + HALF;
        shifted_w = sum_w >>> RES_SHIFT;
    end

    // Hold the residual for the whole block.
    always_ff @(posedge clk) begin
        if (!rst_n)
            residual <= '0;
        else if (load)
            residual <= shifted_w[RES_W-1:0];
    end
endmodule

// File: rtl/cdc_lane.sv
// One pixel lane: zero-extends a prediction byte, adds the signed residual and clips.
// Purely combinational; assumes RES_W is wide enough for the residual range.
module cdc_lane #(
    parameter int PIX_W = 8,
    parameter int RES_W = 11
) (
    input  logic [PIX_W-1:0]        pred_pix,
    input  logic signed [RES_W-1:0] residual,
    output logic [PIX_W-1:0]        recon_pix
);
    localparam int BASE_W = (RES_W > PIX_W + 1) ? RES_W : PIX_W + 1;
    localparam int SW     = BASE_W + 1;
    localparam logic signed [SW-1:0] PIX_MAX = SW'((1 << PIX_W) - 1);

    logic signed [SW-1:0] sum_w;

    // Add and saturate to the unsigned pixel range.
    always_comb begin
        sum_w = $signed({{(SW - PIX_W){1'b0}}, pred_pix})
              + $signed({{(SW - RES_W){residual[RES_W-1]}}, residual});
        if (sum_w < 0)
            recon_pix = '0;
        else if (sum_w > PIX_MAX)
            recon_pix = '1;
        else
            recon_pix = sum_w[PIX_W-1:0];
    end
endmodule

// File: rtl/cdc_seq.sv
// Row sequencer: idle until start, then accepts ROWS rows and returns to idle.
// Assumes start is ignored while a block runs and rows are ignored while idle.
module cdc_seq #(
    parameter int ROWS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic in_valid,
    output logic busy,
    output logic load,
    output logic accept,
    output logic last
);
    import chroma_dc_pkg::*;

    localparam int CNT_W = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ROWS - 1);

    phase_t           phase;
    logic [CNT_W-1:0] row_cnt;

    // Decode strobes from the current phase.
    always_comb begin
        busy   = (phase == PH_RUN);
        load   = start && !busy;
        accept = in_valid && busy;
        last   = accept && (row_cnt == LAST_IDX);
    end

    // Phase and row counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            row_cnt <= '0;
        end else if (load) begin
            phase   <= PH_RUN;
            row_cnt <= '0;
        end else if (accept) begin
            row_cnt <= row_cnt + 1'b1;
            if (last)
                phase <= PH_IDLE;
        end
    end
endmodule

// File: rtl/chroma_dc_recon.sv
// Top: DC-only reconstruction of one chroma component in interleaved rows.
// Even bytes carry the rebuilt component; odd bytes of cur_row pass through.
// Assumes dc_in is already dequantized; one merged row returns per accepted row.
module chroma_dc_recon #(
    parameter int DC_W  = 16,
    parameter int PIX_W = 8,
    parameter int NPIX  = 4,
    parameter int ROWS  = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [DC_W-1:0]        dc_in,
    input  logic                   in_valid,
    input  logic [2*NPIX*PIX_W-1:0] pred_row,
    input  logic [2*NPIX*PIX_W-1:0] cur_row,
    output logic                   busy,
    output logic                   out_valid,
    output logic [2*NPIX*PIX_W-1:0] out_row,
    output logic                   done
);
    import chroma_dc_pkg::*;

    localparam int RES_W = DC_W + 1 - RES_SHIFT;
    localparam int ROW_W = 2 * NPIX * PIX_W;

    logic                    load_w;
    logic                    accept_w;
    logic                    last_w;
    logic signed [RES_W-1:0] residual_w;
    logic [ROW_W-1:0]        merged_w;

    cdc_seq #(.ROWS(ROWS)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .in_valid (in_valid),
        .busy     (busy),
        .load     (load_w),
        .accept   (accept_w),
        .last     (last_w)
    );

    cdc_residual #(.DC_W(DC_W), .RES_W(RES_W)) u_res (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_w),
        .dc_in    (dc_in),
        .residual (residual_w)
    );

    // One lane per component pixel; odd bytes copied from the current row.
    for (genvar gi = 0; gi < NPIX; gi++) begin : g_lane
        logic [PIX_W-1:0] pix_w;
        cdc_lane #(.PIX_W(PIX_W), .RES_W(RES_W)) u_lane (
            .pred_pix  (pred_row[(2*gi)*PIX_W +: PIX_W]),
            .residual  (residual_w),
            .recon_pix (pix_w)
        );
        assign merged_w[(2*gi)*PIX_W   +: PIX_W] = pix_w;
        assign merged_w[(2*gi+1)*PIX_W +: PIX_W] = cur_row[(2*gi+1)*PIX_W +: PIX_W];
    end

    // Output register with valid and end-of-block flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            done      <= 1'b0;
            out_row   <= '0;
        end else begin
            out_valid <= accept_w;
            done      <= last_w;
            if (accept_w)
                out_row <= merged_w;
        end
    end
endmodule

// File: rtl/chroma_dc_recon_chk.sv
// Protocol and merge checks for chroma_dc_recon, observing its ports only.
module chroma_dc_recon_chk #(
    parameter int DC_W  = 16,
    parameter int PIX_W = 8,
    parameter int NPIX  = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start,
    input logic                    in_valid,
    input logic [2*NPIX*PIX_W-1:0] cur_row,
    input logic                    busy,
    input logic                    out_valid,
    input logic [2*NPIX*PIX_W-1:0] out_row,
    input logic                    done
);
    localparam int ROW_W = 2 * NPIX * PIX_W;

    function automatic logic [ROW_W-1:0] odd_mask();
        logic [ROW_W-1:0] m;
        m = '0;
        for (int i = 0; i < NPIX; i++)
            m[(2*i+1)*PIX_W +: PIX_W] = '1;
        return m;
    endfunction

    localparam logic [ROW_W-1:0] ODD_M = odd_mask();

    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_odd_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && busy) |=> ((out_row & ODD_M) == ($past(cur_row) & ODD_M)));

    assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && busy) |=> out_valid);

    assert_done_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (out_valid && !busy));

    assert_idle_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> (!out_valid && $stable(out_row)));
endmodule

bind chroma_dc_recon chroma_dc_recon_chk #(
    .DC_W(DC_W), .PIX_W(PIX_W), .NPIX(NPIX)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .cur_row(cur_row), .busy(busy), .out_valid(out_valid),
    .out_row(out_row), .done(done)
);

// File: tb/chroma_dc_recon_bench.sv
module chroma_dc_recon_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [15:0] dc_in;
    logic        in_valid;
    logic [63:0] pred_row;
    logic [63:0] cur_row;
    logic        busy;
    logic        out_valid;
    logic [63:0] out_row;
    logic        done;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chroma_dc_recon u_chroma_dc_recon (
        .clk(clk), .rst_n(rst_n), .start(start), .dc_in(dc_in),
        .in_valid(in_valid), .pred_row(pred_row), .cur_row(cur_row),
        .busy(busy), .out_valid(out_valid), .out_row(out_row), .done(done)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int resid(input int dc);
        return (dc + 32) >>> 6;
    endfunction

    function automatic logic [63:0] model(input int dc, input logic [63:0] p, input logic [63:0] c);
        logic [63:0] r;
        int v;
        r = c;
        for (int i = 0; i < 4; i++) begin
            v = int'(p[16*i +: 8]) + resid(dc);
            if (v < 0) v = 0;
            if (v > 255) v = 255;
            r[16*i +: 8] = v[7:0];
        end
        return r;
    endfunction

    function automatic logic [63:0] pattern(input int seed, input int row);
        logic [63:0] r;
        for (int k = 0; k < 8; k++)
            r[8*k +: 8] = 8'((seed * 37 + row * 11 + k * 29) & 255);
        return r;
    endfunction

    task automatic do_start(input int dc);
        @(negedge clk);
        start = 1'b1;
        dc_in = 16'(dc);
        @(negedge clk);
        start = 1'b0;
    endtask

    // Send one row; checks merged result and done flag.
    task automatic do_row(input int dc, input int seed, input int row, input string req);
        logic [63:0] p, c;
        p = pattern(seed, row);
        c = pattern(seed + 101, row);
        pred_row = p;
        cur_row  = c;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " R5 out_valid"}, {63'd0, out_valid}, 64'd1);
        check({req, " R3 R4 row"}, out_row, model(dc, p, c));
        check("R6 done", {63'd0, done}, {63'd0, row == 3});
    endtask

    task automatic run_block(input int dc, input int seed, input string req);
        do_start(dc);
        check("R2 busy after start", {63'd0, busy}, 64'd1);
        for (int r = 0; r < 4; r++) do_row(dc, seed, r, req);
        check("R6 idle after done", {63'd0, busy}, 64'd0);
    endtask

    task automatic t_reset();
        check("R1 busy", {63'd0, busy}, 64'd0);
        check("R1 out_valid", {63'd0, out_valid}, 64'd0);
        check("R1 done", {63'd0, done}, 64'd0);
        check("R1 out_row", out_row, 64'd0);
    endtask

    task automatic t_rounding();
        run_block(31, 1, "R2 dc31");
        run_block(32, 2, "R2 dc32");
        run_block(-33, 3, "R2 dc-33");
        run_block(100, 4, "R3 dc100");
    endtask

    task automatic t_clip();
        run_block(32767, 5, "R3 clip high");
        run_block(-32768, 6, "R3 clip low");
    endtask

    task automatic t_idle_ignore();
        logic [63:0] held;
        @(negedge clk);
        held = out_row;
        pred_row = 64'hFFFF_FFFF_FFFF_FFFF;
        cur_row  = 64'h1234_5678_9ABC_DEF0;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R7 no out_valid", {63'd0, out_valid}, 64'd0);
        check("R7 out_row held", out_row, held);
        check("R7 still idle", {63'd0, busy}, 64'd0);
    endtask

    task automatic t_start_ignored();
        do_start(640);
        do_row(640, 7, 0, "R8");
        do_start(-6400);
        for (int r = 1; r < 4; r++) do_row(640, 7, r, "R8 start ignored");
        check("R8 idle after done", {63'd0, busy}, 64'd0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; dc_in = '0; in_valid = 1'b0;
        pred_row = '0; cur_row = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rounding();
        t_clip();
        t_idle_ignore();
        t_start_ignored();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule